// File: doc/BRIEF.md
# Two-Wire Serial Interface Status Flag Register

This block is the status register of a two-wire serial interface as software sees it. It keeps three sticky event flags. The abnormal-stop flag records a stop condition that arrived while a frame was still moving. The normal-stop flag records a stop condition that arrived after the frame had finished. The continuous-transfer flag records the completion of one frame in a back-to-back transfer. The bus engine supplies single-cycle event pulses, the current operating mode and an address-match qualifier. The block turns these into flag updates and into a same-cycle set request for the interface's shared interrupt flag, which lives outside this block.

Software reads the flags through a simple strobe-based register port. A flag can only be cleared by writing 0 to its bit after a read has shown that bit as 1. When the shared interrupt flag is cleared elsewhere, that clear is reported here and also removes these flags. The continuous-transfer flag is removed by that clear only while the interface is enabled. A hardware set event always beats a clear that arrives in the same cycle.

Top module: `bus_status_flags`

## Requirements
- R1: After reset all three flags are 0, `reg_rdata_o` is 8'h00 and `irq_set_o` is 0 while no event input is active.
- R2: The abnormal-stop flag is read at bit 7. It becomes 1 on the clock edge that samples `stop_det_i`=1 with `frame_busy_i`=1 and `mode_slave_bus_i`=1. With `mode_slave_bus_i`=0, a stop does not set it.
- R3: The normal-stop flag is read at bit 6. It becomes 1 on the edge that samples `stop_det_i`=1 with `frame_busy_i`=0 and `mode_slave_bus_i`=1. With `mode_slave_bus_i`=0, a stop does not set it.
- R4: The continuous-transfer flag is read at bit 5. In slave bus mode, a `tx_empty_set_i` or `rx_full_set_i` pulse sets it only when `addr_match2_i`=1.
- R5: When `mode_master_i`, `mode_sync_i` or `mode_raw_i` is 1, every `tx_empty_set_i` or `rx_full_set_i` pulse sets the continuous-transfer flag, whatever the value of `addr_match2_i`.
- R6: `irq_set_o` is 1, combinationally, in exactly the cycles whose edge sets the continuous-transfer flag (the same condition as in R4/R5).
- R7: A write (`reg_wr_i`=1) with 0 in a flag's bit clears that flag only if a read (`reg_rd_i`=1) returned the flag as 1 after it last became 1 and no clear has happened since. A write with 1 in the bit has no effect.
- R8: `irq_clr_i`=1 clears both stop flags. It clears the continuous-transfer flag only when `enable_i`=1.
- R9: If a set event and any clear meet on the same edge, the flag stays 1. The read that armed the clear is forgotten, so a further write of 0 has no effect until a new read returns the flag as 1.
- R10: Bits 4 to 0 of `reg_rdata_o` always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_rd_i | input | 1 | Register read strobe; arms the flags currently at 1 for clearing |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data; 0 in a flag bit requests a clear |
| reg_rdata_o | output | 8 | Register contents: flags at bits 7..5, zeros below |
| stop_det_i | input | 1 | Stop condition detected (pulse) |
| frame_busy_i | input | 1 | A frame is still in progress |
| tx_empty_set_i | input | 1 | Transmit data-empty flag is being set (pulse) |
| rx_full_set_i | input | 1 | Receive data-full flag is being set (pulse) |
| mode_slave_bus_i | input | 1 | Slave mode with bus format |
| mode_master_i | input | 1 | Master mode with bus format |
| mode_sync_i | input | 1 | Clocked synchronous serial mode |
| mode_raw_i | input | 1 | Formatless mode |
| addr_match2_i | input | 1 | Secondary address-match qualifier |
| enable_i | input | 1 | Interface enable |
| irq_clr_i | input | 1 | The shared interrupt flag is being cleared |
| irq_set_o | output | 1 | Request to set the shared interrupt flag this cycle |

## Verification
Software can see the internal state of this block only through the flag bits at `reg_rdata_o` and through whether a later write of 0 takes effect. A wrongly captured or wrongly dropped read arming does not show up when it happens. It shows only at the first write of 0 that follows: on the next edge, the flag is cleared when it should not be, or stays set when it should clear. A wrong set decode shows in the bit one edge after the event pulse, and a wrong `irq_set_o` shows in the same cycle as the pulse. For this reason the reference model is compared against both outputs on every cycle. The stimulus places writes right after reads, after set events and after collisions, so that arming faults are seen within a cycle or two.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_HI   = 7;
  localparam int unsigned FLAG_LO   = FLAG_HI - NUM_FLAGS + 1;

  // flag vector index, LSB first (bit FLAG_LO + idx in the register)
  localparam int unsigned IDX_CONT = 0;
  localparam int unsigned IDX_NRM  = 1;
  localparam int unsigned IDX_ABN  = 2;

  typedef struct packed {
    logic stop_det;
    logic frame_busy;
    logic tx_empty_set;
    logic rx_full_set;
  } bus_evt_t;

  typedef struct packed {
    logic slave_bus;
    logic master;
    logic sync;
    logic raw;
  } bus_mode_t;
endpackage

// File: rtl/bsf_event_decode.sv
module bsf_event_decode
  import bsf_pkg::*;
#(
  parameter int unsigned N = NUM_FLAGS
) (
  input  bus_evt_t     evt_i,
  input  bus_mode_t    mode_i,
  input  logic         addr_match2_i,
  output logic [N-1:0] set_o,
  output logic         irq_set_o
);
  logic data_evt;
  logic cont_qual;
  logic cont_set;

  assign data_evt  = evt_i.tx_empty_set | evt_i.rx_full_set;
  assign cont_qual = (mode_i.slave_bus & addr_match2_i) | mode_i.master | mode_i.sync | mode_i.raw;
  assign cont_set  = data_evt & cont_qual;

  always_comb begin
    set_o           = '0;
    set_o[IDX_CONT] = cont_set;
    set_o[IDX_NRM]  = mode_i.slave_bus & evt_i.stop_det & ~evt_i.frame_busy;
    set_o[IDX_ABN]  = mode_i.slave_bus & evt_i.stop_det &  evt_i.frame_busy;
  end

  assign irq_set_o = cont_set;
endmodule

// File: rtl/bsf_flag_cell.sv
module bsf_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_zero_i,
  input  logic hw_clr_i,
  output logic flag_o
);
  logic flag_q;
  logic arm_q;
  logic sw_clr;
  logic any_clr;

  assign sw_clr  = wr_zero_i & arm_q;
  assign any_clr = sw_clr | hw_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
      // a colliding clear drops the arming
      if (any_clr)   arm_q <= 1'b0;
      else if (rd_i) arm_q <= flag_q;
    end else if (any_clr) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (rd_i) begin
      arm_q  <= flag_q;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bus_status_flags.sv
module bus_status_flags
  import bsf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             stop_det_i,
  input  logic             frame_busy_i,
  input  logic             tx_empty_set_i,
  input  logic             rx_full_set_i,
  input  logic             mode_slave_bus_i,
  input  logic             mode_master_i,
  input  logic             mode_sync_i,
  input  logic             mode_raw_i,
  input  logic             addr_match2_i,
  input  logic             enable_i,
  input  logic             irq_clr_i,
  output logic             irq_set_o
);
  bus_evt_t             evt;
  bus_mode_t            mode;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] wr_zero;

  assign evt  = '{stop_det: stop_det_i, frame_busy: frame_busy_i,
                  tx_empty_set: tx_empty_set_i, rx_full_set: rx_full_set_i};
  assign mode = '{slave_bus: mode_slave_bus_i, master: mode_master_i,
                  sync: mode_sync_i, raw: mode_raw_i};

  bsf_event_decode #(.N(NUM_FLAGS)) u_dec (
    .evt_i         (evt),
    .mode_i        (mode),
    .addr_match2_i (addr_match2_i),
    .set_o         (set_vec),
    .irq_set_o     (irq_set_o)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic hw_clr;
    if (i == IDX_CONT) begin : g_gated
      assign hw_clr = irq_clr_i & enable_i;
    end else begin : g_plain
      assign hw_clr = irq_clr_i;
    end
    assign wr_zero[i] = reg_wr_i & ~reg_wdata_i[FLAG_LO+i];

    bsf_flag_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_vec[i]),
      .rd_i      (reg_rd_i),
      .wr_zero_i (wr_zero[i]),
      .hw_clr_i  (hw_clr),
      .flag_o    (flags[i])
    );
  end

  always_comb begin
    reg_rdata_o                  = '0;
    reg_rdata_o[FLAG_HI:FLAG_LO] = flags;
  end
endmodule

// File: rtl/bus_status_flags_chk.sv
module bus_status_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       stop_det_i,
  input logic       frame_busy_i,
  input logic       mode_slave_bus_i,
  input logic       enable_i,
  input logic       irq_clr_i,
  input logic       irq_set_o
);
  AST_ABN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && frame_busy_i && mode_slave_bus_i) |=> reg_rdata_o[7]); // R2
  AST_NRM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && !frame_busy_i && mode_slave_bus_i) |=> reg_rdata_o[6]); // R3
  AST_IRQ_WITH_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_o |=> reg_rdata_o[5]); // R6
  AST_WR_ONE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[7] && reg_rdata_o[7] && !irq_clr_i) |=> reg_rdata_o[7]); // R7
  AST_IRQCLR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !stop_det_i) |=> (!reg_rdata_o[7] && !reg_rdata_o[6])); // R8
  AST_IRQCLR_CONT_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !enable_i && reg_rdata_o[5]) |=> reg_rdata_o[5]); // R8
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> (reg_rdata_o[4:0] == 5'd0)); // R10
endmodule

bind bus_status_flags bus_status_flags_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .reg_wr_i         (reg_wr_i),
  .reg_wdata_i      (reg_wdata_i),
  .reg_rdata_o      (reg_rdata_o),
  .stop_det_i       (stop_det_i),
  .frame_busy_i     (frame_busy_i),
  .mode_slave_bus_i (mode_slave_bus_i),
  .enable_i         (enable_i),
  .irq_clr_i        (irq_clr_i),
  .irq_set_o        (irq_set_o)
);

// File: tb/bus_status_flags_bench.sv
module bus_status_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 8'hFF;
  logic [7:0] rdata;
  logic stop = 0, busy = 0, empty = 0, full = 0;
  logic m_slave = 0, m_master = 0, m_sync = 0, m_raw = 0;
  logic match = 0, en = 0, iclr = 0;
  logic irq;

  int total = 0, fails = 0;
  bit finished = 0;

  // model: index 0 -> bit7 abnormal, 1 -> bit6 normal, 2 -> bit5 continuous
  bit mflag[3];
  bit marm[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_status_flags u_bus_status_flags (
    .clk_i(clk), .rst_ni(rst_n), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .stop_det_i(stop),
    .frame_busy_i(busy), .tx_empty_set_i(empty), .rx_full_set_i(full),
    .mode_slave_bus_i(m_slave), .mode_master_i(m_master), .mode_sync_i(m_sync),
    .mode_raw_i(m_raw), .addr_match2_i(match), .enable_i(en),
    .irq_clr_i(iclr), .irq_set_o(irq)
  );

  function automatic bit exp_cont();
    return (empty || full) && ((m_slave && match) || m_master || m_sync || m_raw);
  endfunction

  function automatic logic [7:0] exp_rdata();
    return {mflag[0], mflag[1], mflag[2], 5'b00000};
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_set actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit setv[3];
    bit hw[3];
    setv[0] = m_slave && stop && busy;
    setv[1] = m_slave && stop && !busy;
    setv[2] = exp_cont();
    hw[0] = iclr;
    hw[1] = iclr;
    hw[2] = iclr && en;
    for (int i = 0; i < 3; i++) begin
      bit clr;
      bit old;
      old = mflag[i];
      clr = hw[i] || (wr && !wdata[7-i] && marm[i]);
      if (setv[i]) begin
        mflag[i] = 1;
        if (clr) marm[i] = 0;
        else if (rd) marm[i] = old;
      end else if (clr) begin
        mflag[i] = 0;
        marm[i] = 0;
      end else if (rd) begin
        marm[i] = old;
      end
    end
  endtask

  // inputs already driven after a negedge
  task automatic cyc(string tag);
    #1;
    check1(tag, irq, exp_cont());
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check8(tag, rdata, exp_rdata());
    rd = 0; wr = 0; wdata = 8'hFF; stop = 0; busy = 0;
    empty = 0; full = 0; iclr = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mflag[i] = 0; marm[i] = 0; end
    repeat (2) @(negedge clk);
    check8("R1", rdata, 8'h00);
    check1("R1", irq, 1'b0);
    rst_n = 1;
    cyc("R1");

    // stops outside slave mode do nothing
    m_master = 1; stop = 1; busy = 1; cyc("R2");
    stop = 1; busy = 0; cyc("R3");
    m_master = 0; m_slave = 1;
    stop = 1; busy = 1; cyc("R2");
    stop = 1; busy = 0; cyc("R3");

    // clear without read, write 1, then proper clear
    wr = 1; wdata = 8'h00; cyc("R7");
    rd = 1; cyc("R7");
    wr = 1; wdata = 8'hE0; cyc("R7");
    wr = 1; wdata = 8'h40; cyc("R7");
    wr = 1; wdata = 8'h00; cyc("R7");

    // continuous flag in slave mode
    empty = 1; match = 0; cyc("R4");
    full = 1; match = 0; cyc("R4");
    empty = 1; match = 1; cyc("R4");
    rd = 1; cyc("R6");
    wr = 1; wdata = 8'hDF; cyc("R7");
    m_slave = 0;
    full = 1; match = 1; cyc("R4");
    match = 0;

    // master / sync / formatless
    m_master = 1; full = 1; cyc("R5");
    rd = 1; cyc("R5");
    wr = 1; wdata = 8'h00; cyc("R5");
    m_master = 0; m_sync = 1; empty = 1; cyc("R5");
    rd = 1; cyc("R5");
    wr = 1; wdata = 8'h00; cyc("R5");
    m_sync = 0; m_raw = 1; full = 1; empty = 1; cyc("R6");
    m_raw = 0;

    // shared-clear behaviour
    m_slave = 1;
    stop = 1; busy = 1; cyc("R8");
    stop = 1; busy = 0; cyc("R8");
    en = 0; iclr = 1; cyc("R8");
    en = 1; iclr = 1; cyc("R8");

    // collisions
    stop = 1; busy = 1; cyc("R9");
    rd = 1; cyc("R9");
    wr = 1; wdata = 8'h00; stop = 1; busy = 1; cyc("R9");
    wr = 1; wdata = 8'h00; cyc("R9");
    rd = 1; cyc("R9");
    wr = 1; wdata = 8'h00; cyc("R9");
    stop = 1; busy = 0; iclr = 1; cyc("R9");
    wr = 1; wdata = 8'h00; cyc("R9");
    iclr = 1; cyc("R8");

    // reserved bits
    wr = 1; wdata = 8'h1F; cyc("R10");
    rd = 1; cyc("R10");
    check8("R10", rdata & 8'h1F, 8'h00);

    finished = 1;
    summary();
    $finish;
  end
endmodule